// File: doc/BRIEF.md
# EEPROM Page Writer with Acknowledge Polling

This block is a two-wire bus controller that performs byte and page writes to a serial EEPROM target. A command carries the 7-bit device address, the word address and a byte count. Data bytes reach the engine through a small ready/valid stream that fills an internal queue. The engine builds the whole frame itself: Start, control byte with the write direction bit, word address bytes, data bytes, and a closing Stop that launches the target's internal programming cycle. It produces the clock on `scl_o` and pulls the data line low through `sda_oe` in open-drain fashion.

After the Stop it does not wait a fixed worst-case time. It polls at once. Each poll is a Start followed by the control byte in write direction. A poll the target does not acknowledge is closed with a Stop, and the next poll follows. The first acknowledged poll is closed with a Stop and the command finishes. A missing acknowledge on the control, address or data bytes ends the command with an error. Polling that never succeeds ends with a timeout. A byte count outside 1..`PAGE_BYTES` is refused without any bus traffic.

Top module: `eeprom_ackpoll_writer`

## Requirements
- R1: After reset, `scl_o`=1, `sda_oe`=0, `busy`=0, `done`=0, `err`=0 and `cmd_ready`=1.
- R2: A write frame sends, MSB first, the control byte {device address, 0}, then the word address bytes with the most significant byte first, then the data bytes in the order they entered the stream. Each byte is followed by a ninth clock during which SDA is released.
- R3: During a bit, SDA changes only while SCL is low. A Start is SDA falling while SCL is high. A Stop is SDA rising while SCL is high.
- R4: When the last data byte is acknowledged, a Stop follows and polling starts at once. Each poll is a Start plus the write control byte. An unacknowledged poll is closed with a Stop before the next Start.
- R5: The first acknowledged poll is closed with a Stop and ends the command with `err_code`=0. `poll_cnt` holds the number of polls sent, including the acknowledged one.
- R6: From Start to the first Stop, a write produces 9×(1+ADDR_BYTES+len)+1 rising SCL edges. Each poll adds 10.
- R7: An ACK bit read as 1 on the control, address or data byte is followed at once by a Stop. No further byte and no poll follow. The command ends with `err_code`=1, and bytes still queued are discarded.
- R8: A count of 0 or above `PAGE_BYTES` produces no SCL edge. `done` rises in the second cycle after acceptance, with `err_code`=2.
- R9: If MAX_POLLS polls are all unacknowledged, the command ends with `err_code`=3 and `poll_cnt`=MAX_POLLS.
- R10: `busy` is 1 from the accepting clock edge until `done`. While busy, `cmd_ready` is 0 and `cmd_valid` has no effect.
- R11: `done` is a one-cycle pulse. `err` (1 for any nonzero code) and `err_code` stay valid until the next command is accepted.
- R12: If the queue is empty when a data byte is due, SCL is held low until a byte arrives. The frame then continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when both high |
| cmd_dev | input | 7 | Target device address |
| cmd_waddr | input | 8*ADDR_BYTES | Word address |
| cmd_len | input | clog2(PAGE_BYTES+1) | Number of data bytes |
| wd_valid | input | 1 | Data byte offered |
| wd_ready | output | 1 | Queue has room |
| wd_data | input | 8 | Data byte |
| scl_o | output | 1 | Bus clock |
| sda_oe | output | 1 | 1 pulls the data line low |
| sda_i | input | 1 | Data line level |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command failed |
| err_code | output | 2 | 0 ok, 1 no acknowledge, 2 bad count, 3 poll timeout |
| poll_cnt | output | clog2(MAX_POLLS+1) | Polls issued by the last command |

## Verification
In one byte-end step the engine can both detect a missing acknowledge and reach the end of the data count. That is where the switch into polling would happen. The bench provokes this by having the target refuse the final data byte of a page. The correct result is a single frame with no poll Start after it, `poll_cnt` 0 and `err_code` 1. Refused polls are also run up to exactly MAX_POLLS, and to one fewer, to separate an acknowledge from a timeout on the same poll.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    WR_OK      = 2'd0,
    WR_NACK    = 2'd1,
    WR_BADLEN  = 2'd2,
    WR_TIMEOUT = 2'd3
  } wr_status_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BIT, ST_STOP, ST_FETCH, ST_FIN
  } eng_state_e;

  typedef enum logic [1:0] {
    PH_CTRL, PH_ADDR, PH_DATA, PH_POLL
  } frame_phase_e;
endpackage

// File: rtl/eepw_qtick.sv
module eepw_qtick #(
  parameter int unsigned QTR_CYC = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(QTR_CYC - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  generate
    if (QTR_CYC > 1) begin : g_chk
      // quarter phases are spaced by the divider: never two ticks back to back (R6)
      p_tick_spacing_r6: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/eepw_fifo.sv
module eepw_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  // the sequencer only fetches a byte that is present (R12)
  p_pop_nonempty_r12: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/eeprom_ackpoll_writer.sv
module eeprom_ackpoll_writer
  import eepw_pkg::*;
#(
  parameter int unsigned QTR_CYC    = 125,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned ADDR_BYTES = 2,
  parameter int unsigned MAX_POLLS  = 200,
  localparam int unsigned LEN_W     = $clog2(PAGE_BYTES + 1),
  localparam int unsigned WADDR_W   = 8 * ADDR_BYTES,
  localparam int unsigned POLL_W    = $clog2(MAX_POLLS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [6:0]         cmd_dev,
  input  logic [WADDR_W-1:0] cmd_waddr,
  input  logic [LEN_W-1:0]   cmd_len,
  input  logic               wd_valid,
  output logic               wd_ready,
  input  logic [7:0]         wd_data,
  output logic               scl_o,
  output logic               sda_oe,
  input  logic               sda_i,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [1:0]         err_code,
  output logic [POLL_W-1:0]  poll_cnt
);
  localparam int unsigned IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  eng_state_e        st;
  frame_phase_e      ph;
  wr_status_e        code_q;
  logic [1:0]        q;
  logic [3:0]        bitn;
  logic [7:0]        shreg;
  logic [6:0]        dev_q;
  logic [WADDR_W-1:0] wsh;
  logic [LEN_W-1:0]  left_q;
  logic [IDX_W-1:0]  aidx;
  logic              nack_q, then_poll;
  logic              scl_q, oe_q, busy_q, done_q, err_q;
  logic [POLL_W-1:0] polls_q;

  logic tick, tick_run;
  logic q_full, q_empty, q_pop, q_flush;
  logic [7:0] q_dout;

  assign tick_run = (st == ST_START) || (st == ST_BIT) || (st == ST_STOP);
  assign q_pop    = (st == ST_FETCH) && !q_empty;
  assign q_flush  = (st == ST_FIN) && (code_q != WR_OK);

  eepw_qtick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk(clk), .rst(rst), .run(tick_run), .tick(tick)
  );

  eepw_fifo #(.DEPTH(PAGE_BYTES), .W(8)) u_fifo (
    .clk(clk), .rst(rst), .flush(q_flush),
    .push(wd_valid && !q_full), .din(wd_data), .full(q_full),
    .pop(q_pop), .dout(q_dout), .empty(q_empty)
  );

  // sequencer: frame phases, bit counting, acknowledge decisions
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= PH_CTRL;
      code_q    <= WR_OK;
      q         <= '0;
      bitn      <= '0;
      shreg     <= '0;
      dev_q     <= '0;
      wsh       <= '0;
      left_q    <= '0;
      aidx      <= '0;
      nack_q    <= 1'b0;
      then_poll <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      polls_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          busy_q  <= 1'b1;
          err_q   <= 1'b0;
          polls_q <= '0;
          dev_q   <= cmd_dev;
          wsh     <= cmd_waddr;
          left_q  <= cmd_len;
          if (cmd_len == '0 || cmd_len > LEN_W'(PAGE_BYTES)) begin
            code_q <= WR_BADLEN;
            st     <= ST_FIN;
          end else begin
            code_q <= WR_OK;
            ph     <= PH_CTRL;
            shreg  <= {cmd_dev, 1'b0};
            bitn   <= '0;
            q      <= '0;
            st     <= ST_START;
          end
        end
        ST_START: if (tick) begin
          q <= q + 1'b1;
          if (q == 2'd3) st <= ST_BIT;
        end
        ST_BIT: if (tick) begin
          q <= q + 1'b1;
          if (q == 2'd2 && bitn == 4'd8) nack_q <= sda_i;
          if (q == 2'd3) begin
            if (bitn != 4'd8) begin
              shreg <= {shreg[6:0], 1'b0};
              bitn  <= bitn + 1'b1;
            end else begin
              bitn <= '0;
              case (ph)
                PH_CTRL: if (nack_q) begin
                  code_q <= WR_NACK; then_poll <= 1'b0; st <= ST_STOP;
                end else begin
                  ph    <= PH_ADDR;
                  aidx  <= IDX_W'(ADDR_BYTES - 1);
                  shreg <= wsh[WADDR_W-1 -: 8];
                  wsh   <= wsh << 8;
                end
                PH_ADDR: if (nack_q) begin
                  code_q <= WR_NACK; then_poll <= 1'b0; st <= ST_STOP;
                end else if (aidx != '0) begin
                  aidx  <= aidx - 1'b1;
                  shreg <= wsh[WADDR_W-1 -: 8];
                  wsh   <= wsh << 8;
                end else begin
                  ph <= PH_DATA;
                  st <= ST_FETCH;
                end
                PH_DATA: if (nack_q) begin
                  code_q <= WR_NACK; then_poll <= 1'b0; st <= ST_STOP;
                end else begin
                  left_q <= left_q - 1'b1;
                  if (left_q == LEN_W'(1)) begin
                    then_poll <= 1'b1;
                    st        <= ST_STOP;
                  end else begin
                    st <= ST_FETCH;
                  end
                end
                default: begin
                  polls_q <= polls_q + 1'b1;
                  st      <= ST_STOP;
                  if (!nack_q) begin
                    then_poll <= 1'b0;
                  end else if ((polls_q + 1'b1) == POLL_W'(MAX_POLLS)) begin
                    code_q    <= WR_TIMEOUT;
                    then_poll <= 1'b0;
                  end else begin
                    then_poll <= 1'b1;
                  end
                end
              endcase
            end
          end
        end
        ST_FETCH: if (!q_empty) begin
          shreg <= q_dout;
          bitn  <= '0;
          q     <= '0;
          st    <= ST_BIT;
        end
        ST_STOP: if (tick) begin
          q <= q + 1'b1;
          if (q == 2'd3) begin
            if (then_poll) begin
              ph    <= PH_POLL;
              shreg <= {dev_q, 1'b0};
              bitn  <= '0;
              st    <= ST_START;
            end else begin
              st <= ST_FIN;
            end
          end
        end
        default: begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
          err_q  <= (code_q != WR_OK);
          st     <= ST_IDLE;
        end
      endcase
    end
  end

  // registered bus pins from the quarter phase of the current symbol
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      case (st)
        ST_START: begin scl_q <= (q != 2'd3); oe_q <= (q != 2'd0); end
        ST_BIT:   begin scl_q <= (q == 2'd1 || q == 2'd2); oe_q <= (bitn != 4'd8) && !shreg[7]; end
        ST_STOP:  begin scl_q <= (q != 2'd0); oe_q <= (q < 2'd2); end
        ST_FETCH: scl_q <= 1'b0;
        default:  begin scl_q <= 1'b1; oe_q <= 1'b0; end
      endcase
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign wd_ready  = !q_full;
  assign scl_o     = scl_q;
  assign sda_oe    = oe_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign err_code  = code_q;
  assign poll_cnt  = polls_q;

  // data line holds still while the clock is high inside a bit (R3)
  p_sda_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BIT && scl_q && $past(scl_q)) |-> $stable(oe_q));
  // completion leaves the busy window (R10)
  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // completion is a single-cycle pulse (R11)
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // a refused count finishes two edges after acceptance (R8)
  p_badlen_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_len == '0 || cmd_len > LEN_W'(PAGE_BYTES)))
      |=> ##1 (done && err_code == 2'd2));
  // the poll counter never passes its ceiling (R9)
  p_poll_bound_r9: assert property (@(posedge clk) disable iff (rst)
    poll_cnt <= POLL_W'(MAX_POLLS));
endmodule

// File: tb/eeprom_ackpoll_writer_bench.sv
module eeprom_ackpoll_writer_bench;
  localparam int QTR = 4, PAGE = 8, AB = 2, MAXP = 6;
  localparam logic [6:0] DEV = 7'h50;
  localparam int NV = 7;
  // vectors: count, refused polls, refused byte index (99 none), code, polls
  localparam int V_LEN   [NV] = '{1, 8, 4, 3, 5, 5, 2};
  localparam int V_BUSY  [NV] = '{2, 0, 5, 6, 0, 0, 0};
  localparam int V_NACK  [NV] = '{99, 99, 99, 99, 1, 7, 0};
  localparam int V_CODE  [NV] = '{0, 0, 0, 3, 1, 1, 1};
  localparam int V_POLLS [NV] = '{3, 1, 6, 6, 0, 0, 0};

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic cmd_valid, cmd_ready, wd_valid, wd_ready, scl_o, sda_oe, sda_i;
  logic busy, done, err;
  logic [6:0] cmd_dev;
  logic [15:0] cmd_waddr;
  logic [3:0] cmd_len;
  logic [7:0] wd_data;
  logic [1:0] err_code;
  logic [2:0] poll_cnt;

  eeprom_ackpoll_writer #(.QTR_CYC(QTR), .PAGE_BYTES(PAGE), .ADDR_BYTES(AB), .MAX_POLLS(MAXP))
    u_eeprom_ackpoll_writer (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dev(cmd_dev),
    .cmd_waddr(cmd_waddr), .cmd_len(cmd_len), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i), .busy(busy),
    .done(done), .err(err), .err_code(err_code), .poll_cnt(poll_cnt));

  // target model
  logic slv_low = 1'b0, sda_line, p_scl = 1'b1, p_sda = 1'b1, ack = 1'b0, fr_nack = 1'b0;
  logic [7:0] shr = 8'h00;
  logic [7:0] rx [16];
  int busy_cfg = 0, nack_idx = 99, busy_left = 0;
  int n_start = 0, n_stop = 0, n_rise = 0, bitc = 0, bytec = 0;
  assign sda_line = !(sda_oe || slv_low);
  assign sda_i = sda_line;

  always @(scl_o or sda_line) begin
    if (scl_o && p_scl && p_sda && !sda_line) begin
      n_start++; bitc = 0; bytec = 0; fr_nack = 1'b0; slv_low = 1'b0;
    end else if (scl_o && p_scl && !p_sda && sda_line) begin
      n_stop++; bitc = 0;
      if (!fr_nack && bytec >= 2 + AB) busy_left = busy_cfg;
    end else if (scl_o && !p_scl) begin
      n_rise++; bitc++;
      if (bitc <= 8) shr = {shr[6:0], sda_line};
      if (bitc == 8) begin
        if (bytec == 0) begin
          if (busy_left > 0) begin ack = 1'b0; busy_left--; end
          else ack = (shr == {DEV, 1'b0}) && (nack_idx != 0);
        end else ack = (bytec != nack_idx);
        if (bytec < 16) rx[bytec] = shr;
        if (!ack) fr_nack = 1'b1;
      end
    end else if (!scl_o && p_scl) begin
      if (bitc == 8) slv_low = ack;
      else if (bitc == 9) begin slv_low = 1'b0; bitc = 0; bytec++; end
    end
    p_scl = scl_o;
    p_sda = sda_line;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    while (!wd_ready) @(negedge clk);
    wd_valid = 1'b1; wd_data = b;
    @(negedge clk);
    wd_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [15:0] wa, input int len);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_dev = DEV; cmd_waddr = wa; cmd_len = 4'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      if (done) return;
      @(negedge clk);
    end
    chk("watchdog expired", 0, 1);
  endtask

  function automatic logic [7:0] dbyte(input int r, input int j);
    return 8'((r * 16) + (j * 3) + 1);
  endfunction

  initial begin
    cmd_valid = 1'b0; wd_valid = 1'b0; cmd_dev = DEV; cmd_waddr = '0; cmd_len = '0; wd_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pins {scl,oe,busy,done,err,ready}",
        int'({scl_o, sda_oe, busy, done, err, cmd_ready}), 6'b100001);

    for (int r = 0; r < NV; r++) begin
      int r0, s0, len, nb, mism;
      logic [15:0] wa;
      logic [7:0] e;
      busy_cfg = V_BUSY[r]; nack_idx = V_NACK[r]; len = V_LEN[r];
      wa = 16'(16'h0123 + r * 16'h0211);
      for (int j = 0; j < len; j++) push(dbyte(r, j));
      r0 = n_rise; s0 = n_start;
      run_cmd(wa, len);
      wait_done();
      chk($sformatf("R5 R7 R9 row %0d err_code", r), int'(err_code), V_CODE[r]);
      chk($sformatf("R11 row %0d err flag", r), int'(err), int'(V_CODE[r] != 0));
      chk($sformatf("R5 R9 row %0d poll_cnt", r), int'(poll_cnt), V_POLLS[r]);
      chk($sformatf("R4 R7 row %0d frame count", r), n_start - s0, 1 + V_POLLS[r]);
      if (V_CODE[r] == 1)
        chk($sformatf("R6 R7 row %0d scl rises", r), n_rise - r0, 9 * (V_NACK[r] + 1) + 1);
      else
        chk($sformatf("R6 row %0d scl rises", r), n_rise - r0, 9 * (1 + AB + len) + 1 + 10 * V_POLLS[r]);
      nb = (V_CODE[r] == 1) ? V_NACK[r] + 1 : 1 + AB + len;
      mism = 0;
      for (int k = 0; k < nb; k++) begin
        e = (k == 0) ? {DEV, 1'b0} : (k == 1) ? wa[15:8] : (k == 2) ? wa[7:0] : dbyte(r, k - 3);
        if (rx[k] != e) mism++;
      end
      chk($sformatf("R2 R7 row %0d byte mismatches", r), mism, 0);
      @(negedge clk);
      chk($sformatf("R11 row %0d done pulse width", r), int'(done), 0);
    end
    nack_idx = 99; busy_cfg = 0;

    // refused counts: zero and one past the page
    for (int t = 0; t < 2; t++) begin
      int r0;
      r0 = n_rise;
      run_cmd(16'h0040, (t == 0) ? 0 : PAGE + 1);
      chk("R8 done not yet", int'(done), 0);
      @(negedge clk);
      chk("R8 done second cycle", int'(done), 1);
      chk("R8 err_code", int'(err_code), 2);
      chk("R8 no scl edge", n_rise - r0, 0);
      @(negedge clk);
      chk("R11 err held after done", int'(err), 1);
    end

    // stall on empty queue, with a command offered while busy
    begin
      int r0, s0, mism;
      r0 = n_rise; s0 = n_start;
      push(8'hA1); push(8'hB2);
      run_cmd(16'h7F10, 4);
      repeat (1500) @(negedge clk);
      chk("R12 scl held low", int'(scl_o), 0);
      chk("R12 rises before stall", n_rise - r0, 9 * (1 + AB + 2));
      chk("R10 busy during stall", int'(busy), 1);
      chk("R10 cmd_ready low while busy", int'(cmd_ready), 0);
      cmd_valid = 1'b1; cmd_len = 4'd1;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      push(8'hC3); push(8'hD4);
      wait_done();
      chk("R12 err_code after stall", int'(err_code), 0);
      chk("R10 no extra frame from ignored command", n_start - s0, 2);
      mism = int'(rx[3] != 8'hA1) + int'(rx[4] != 8'hB2) + int'(rx[5] != 8'hC3) + int'(rx[6] != 8'hD4);
      chk("R12 data after stall", mism, 0);
      repeat (50) @(negedge clk);
      chk("R10 idle after ignored command", int'(busy), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule